// File: doc/BRIEF.md
# Dual-LUT Configurable Logic Cell

This block is one tile of a programmable logic fabric. It holds two 16-entry truth tables that are filled from a serial configuration stream. Once loaded, each table evaluates an arbitrary Boolean function of its own four inputs. The cell can also merge both tables into one function of five inputs, where the extra input picks the table. Either output can be taken straight from the table or through a flip-flop.

A carry mode makes the cell a 2-bit adder slice. A dedicated majority path produces the carries. Each carry is fed into bit 2 of a table address, so two XOR tables produce the sum bits. The carry out goes straight to a neighbouring cell.

In RAM mode the same 32 storage bits serve as a small memory. The user writes it synchronously and reads it combinationally. After reset all outputs stay at 0 until the full configuration word has arrived.

Top module: `lutblk_top`

## Requirements
- R1: After reset, `out_x`, `out_y` and `cout` are 0, and they stay 0 until the configuration word is complete, whatever the other inputs do.
- R2: The 37-bit configuration word is shifted in most significant bit first, one bit per clock in which `cfg_shift` is 1. Bits [15:0] hold table F (entry i at bit i). Bits [31:16] hold table G. Bit 32 is merge, bit 33 is RAM mode, bit 34 registers `out_x`, bit 35 registers `out_y`, and bit 36 is carry mode. The new functions are live from the clock after the 37th bit is taken.
- R3: In plain mode, `out_x` = F[`f_in`] and `out_y` = G[`g_in`]. This is enough for two independent 4-input functions, for example the equal and greater-than outputs of a 2-bit comparator.
- R4: In merge mode, `out_x` = F[`f_in`] when `sel5` is 0 and G[`f_in`] when `sel5` is 1. `out_y` stays G[`g_in`].
- R5: When an output's register bit is set, that output shows the value its table produced at the previous rising edge. When the bit is clear, the output follows the table at once.
- R6: In carry mode, F is addressed by {`f_in`[3], `cin`, `f_in`[1:0]}. The internal carry c1 = majority(`f_in`[0], `f_in`[1], `cin`). G is addressed by {`g_in`[3], c1, `g_in`[1:0]}. `cout` = majority(`g_in`[0], `g_in`[1], c1). Outside carry mode `cout` is 0.
- R7: In RAM mode, `ram_we` = 1 at a rising edge stores `ram_din` at location {`sel5`, `f_in`]. Locations 0 to 15 are F and 16 to 31 are G. `out_x` reads location {`sel5`, `f_in`} combinationally, and `out_y` reads G[`g_in`].
- R8: Outside RAM mode, `ram_we` has no effect on the stored tables.
- R9: Once configuration is complete, further `cfg_shift` pulses have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Take one configuration bit this clock |
| cfg_din | input | 1 | Serial configuration data |
| f_in | input | 4 | Inputs of table F (RAM address low bits) |
| g_in | input | 4 | Inputs of table G |
| sel5 | input | 1 | Fifth input / RAM table select |
| cin | input | 1 | Carry from the neighbouring cell |
| ram_we | input | 1 | RAM write enable |
| ram_din | input | 1 | RAM write data |
| out_x | output | 1 | Output of table F or of the merged function |
| out_y | output | 1 | Output of table G |
| cout | output | 1 | Carry to the neighbouring cell |

## Verification
The properties assume that the configuration stays fixed once complete. The only exception is RAM-mode writes, so reconfiguration always begins with a reset. The bench never changes modes any other way. Inputs are changed only on the falling clock edge, and `ram_we` is held for one rising edge at a time. The registered-output and RAM-write checks therefore see exactly one capture per stimulus.

// File: rtl/lutblk_pkg.sv
package lutblk_pkg;

    localparam int LUT_K  = 4;
    localparam int LUT_N  = 1 << LUT_K;
    localparam int TT_W   = 2 * LUT_N;
    localparam int MODE_W = 5;
    localparam int CFG_W  = TT_W + MODE_W;
    localparam int ADDR_W = LUT_K + 1;

    typedef struct packed {
        logic carry_en;
        logic reg_y;
        logic reg_x;
        logic ram_en;
        logic merge;
    } mode_t;

    typedef struct packed {
        mode_t            mode;
        logic [LUT_N-1:0] tt_g;
        logic [LUT_N-1:0] tt_f;
    } cfg_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/lutblk_cfg.sv
module lutblk_cfg
    import lutblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bit,
    output cfg_t              cfg,
    output logic              done
);
    localparam int CNT_W = $clog2(CFG_W + 1);

    logic [CFG_W-1:0] store;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            store <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else if (!done) begin
            if (shift_en) begin
                store <= {store[CFG_W-2:0], shift_bit};
                cnt   <= cnt + 1'b1;
                if (cnt == CNT_W'(CFG_W - 1))
                    done <= 1'b1;
            end
        end else if (wr_en) begin
            store[wr_addr] <= wr_bit;
        end
    end

    assign cfg = cfg_t'(store);

endmodule

// File: rtl/lutblk_lut.sv
module lutblk_lut #(
    parameter int K = 4,
    localparam int N = 1 << K
) (
    input  logic [N-1:0] tt,
    input  logic [K-1:0] addr,
    output logic         o
);
    assign o = tt[addr];
endmodule

// File: rtl/lutblk_carry.sv
module lutblk_carry
    import lutblk_pkg::*;
(
    input  logic a0,
    input  logic b0,
    input  logic a1,
    input  logic b1,
    input  logic cin,
    output logic c_mid,
    output logic c_out
);
    assign c_mid = maj3(a0, b0, cin);
    assign c_out = maj3(a1, b1, c_mid);
endmodule

// File: rtl/lutblk_outreg.sv
module lutblk_outreg (
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic use_reg,
    input  logic d,
    output logic q
);
    logic ff;

    always_ff @(posedge clk) begin
        if (rst)
            ff <= 1'b0;
        else
            ff <= live ? d : 1'b0;
    end

    always_comb begin
        if (!live)
            q = 1'b0;
        else if (use_reg)
            q = ff;
        else
            q = d;
    end
endmodule

// File: rtl/lutblk_top.sv
module lutblk_top
    import lutblk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_shift,
    input  logic             cfg_din,
    input  logic [LUT_K-1:0] f_in,
    input  logic [LUT_K-1:0] g_in,
    input  logic             sel5,
    input  logic             cin,
    input  logic             ram_we,
    input  logic             ram_din,
    output logic             out_x,
    output logic             out_y,
    output logic             cout
);
    localparam int NREAD = 3;
    localparam int NOUT  = 2;

    cfg_t cfg_q;
    logic cfg_done;
    logic ram_wr;
    logic c_mid, c_out;

    assign ram_wr = cfg_done & cfg_q.mode.ram_en & ram_we;

    lutblk_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_shift),
        .shift_bit(cfg_din),
        .wr_en    (ram_wr),
        .wr_addr  ({sel5, f_in}),
        .wr_bit   (ram_din),
        .cfg      (cfg_q),
        .done     (cfg_done)
    );

    lutblk_carry u_carry (
        .a0   (f_in[0]),
        .b0   (f_in[1]),
        .a1   (g_in[0]),
        .b1   (g_in[1]),
        .cin  (cin),
        .c_mid(c_mid),
        .c_out(c_out)
    );

    // Carry mode replaces address bit 2 of each table with the incoming carry.
    logic [LUT_K-1:0] addr_f, addr_g;
    always_comb begin
        addr_f = f_in;
        addr_g = g_in;
        if (cfg_q.mode.carry_en) begin
            addr_f[2] = cin;
            addr_g[2] = c_mid;
        end
    end

    // Reads: 0 = F at f address, 1 = G at g address, 2 = G at f address.
    logic [LUT_N-1:0] rd_tt   [NREAD];
    logic [LUT_K-1:0] rd_addr [NREAD];
    logic [NREAD-1:0] rd_bit;

    always_comb begin
        rd_tt[0]   = cfg_q.tt_f;
        rd_addr[0] = addr_f;
        rd_tt[1]   = cfg_q.tt_g;
        rd_addr[1] = addr_g;
        rd_tt[2]   = cfg_q.tt_g;
        rd_addr[2] = addr_f;
    end

    for (genvar r = 0; r < NREAD; r++) begin : g_read
        lutblk_lut #(.K(LUT_K)) u_lut (
            .tt  (rd_tt[r]),
            .addr(rd_addr[r]),
            .o   (rd_bit[r])
        );
    end

    logic comb_x, comb_y;
    always_comb begin
        if ((cfg_q.mode.merge || cfg_q.mode.ram_en) && sel5)
            comb_x = rd_bit[2];
        else
            comb_x = rd_bit[0];
        comb_y = rd_bit[1];
    end

    logic [NOUT-1:0] o_d, o_reg, o_q;
    assign o_d   = {comb_y, comb_x};
    assign o_reg = {cfg_q.mode.reg_y, cfg_q.mode.reg_x};

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        lutblk_outreg u_oreg (
            .clk    (clk),
            .rst    (rst),
            .live   (cfg_done),
            .use_reg(o_reg[o]),
            .d      (o_d[o]),
            .q      (o_q[o])
        );
    end

    assign out_x = o_q[0];
    assign out_y = o_q[1];
    assign cout  = cfg_done & cfg_q.mode.carry_en & c_out;

endmodule

// File: rtl/lutblk_chk.sv
module lutblk_chk
    import lutblk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             done,
    input cfg_t             cfg,
    input logic             ram_wr,
    input logic [LUT_K-1:0] f_in,
    input logic [LUT_K-1:0] g_in,
    input logic             sel5,
    input logic             cin,
    input logic             ram_din,
    input logic             comb_x,
    input logic             out_x,
    input logic             out_y,
    input logic             cout
);
    logic [TT_W-1:0] tt_all;
    assign tt_all = {cfg.tt_g, cfg.tt_f};

    a_r1_quiet_until_cfg: assert property (@(posedge clk) disable iff (rst)
        !done |-> (!out_x && !out_y && !cout));

    a_r2_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (done && !ram_wr) |=> $stable(cfg));

    a_r5_reg_x: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done) && cfg.mode.reg_x) |-> (out_x == $past(comb_x)));

    a_r6_carry_maj: assert property (@(posedge clk) disable iff (rst)
        (done && cfg.mode.carry_en) |->
            (cout == maj3(g_in[0], g_in[1], maj3(f_in[0], f_in[1], cin))));

    a_r6_carry_off: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg.mode.carry_en) |-> !cout);

    a_r7_ram_store: assert property (@(posedge clk) disable iff (rst)
        ram_wr |=> (tt_all[$past({sel5, f_in})] == $past(ram_din)));
endmodule

bind lutblk_top lutblk_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .done   (cfg_done),
    .cfg    (cfg_q),
    .ram_wr (ram_wr),
    .f_in   (f_in),
    .g_in   (g_in),
    .sel5   (sel5),
    .cin    (cin),
    .ram_din(ram_din),
    .comb_x (comb_x),
    .out_x  (out_x),
    .out_y  (out_y),
    .cout   (cout)
);

// File: tb/lutblk_top_tb_top.sv
module lutblk_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_shift = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] f_in = '0;
    logic [3:0] g_in = '0;
    logic       sel5 = 1'b0;
    logic       cin = 1'b0;
    logic       ram_we = 1'b0;
    logic       ram_din = 1'b0;
    logic       out_x, out_y, cout;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lutblk_top dut_i (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .f_in(f_in), .g_in(g_in), .sel5(sel5), .cin(cin),
        .ram_we(ram_we), .ram_din(ram_din),
        .out_x(out_x), .out_y(out_y), .cout(cout)
    );

    // Comparator vectors {idx, eq, gt}: A = idx[1:0], B = idx[3:2].
    localparam logic [5:0] CMP_VEC [8] = '{
        6'b0000_10, 6'b0001_01, 6'b0100_00, 6'b0101_10,
        6'b1011_01, 6'b1110_00, 6'b1111_10, 6'b1001_00
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [36:0] mk(input logic [15:0] tf, input logic [15:0] tg,
                                       input logic mg, input logic ram,
                                       input logic rx, input logic ry, input logic cy);
        return {cy, ry, rx, ram, mg, tg, tf};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_shift = 0; ram_we = 0; f_in = '0; g_in = '0; sel5 = 0; cin = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic shift_bits(input logic [36:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            cfg_shift = 1'b1;
            cfg_din   = w[i];
            @(negedge clk);
        end
        cfg_shift = 1'b0;
    endtask

    task automatic configure(input logic [36:0] w);
        do_reset();
        shift_bits(w, 36, 0);
    endtask

    task automatic set_in(input logic [3:0] f, input logic [3:0] g, input logic s, input logic c);
        f_in = f; g_in = g; sel5 = s; cin = c;
        #2;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [36:0] w;
        logic [15:0] tf, tg;
        logic [4:0]  s3;

        // R1: reset state and partial configuration
        do_reset();
        set_in(4'hF, 4'hF, 1, 1);
        chk("R1 reset out_x", out_x, 1'b0);
        chk("R1 reset out_y", out_y, 1'b0);
        chk("R1 reset cout", cout, 1'b0);
        w = mk(16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 0);
        shift_bits(w, 36, 1);
        #2;
        chk("R1 partial out_x", out_x, 1'b0);
        chk("R1 partial out_y", out_y, 1'b0);
        // R2: final bit completes configuration
        shift_bits(w, 0, 0);
        #2;
        chk("R2 live out_x", out_x, 1'b1);
        chk("R2 live out_y", out_y, 1'b1);

        // R2: bit layout
        configure(mk(16'h0001, 16'h8000, 0, 0, 0, 0, 0));
        set_in(4'h0, 4'hF, 0, 0);
        chk("R2 F entry0", out_x, 1'b1);
        chk("R2 G entry15", out_y, 1'b1);
        set_in(4'h1, 4'hE, 0, 0);
        chk("R2 F entry1", out_x, 1'b0);
        chk("R2 G entry14", out_y, 1'b0);

        // R3: 2-bit comparator, F = equal, G = greater-than
        tf = '0; tg = '0;
        for (int i = 0; i < 16; i++) begin
            tf[i] = (i[1:0] == i[3:2]);
            tg[i] = (i[1:0] >  i[3:2]);
        end
        configure(mk(tf, tg, 0, 0, 0, 0, 0));
        for (int v = 0; v < 8; v++) begin
            set_in(CMP_VEC[v][5:2], CMP_VEC[v][5:2], 0, 0);
            chk("R3 cmp eq", out_x, CMP_VEC[v][1]);
            chk("R3 cmp gt", out_y, CMP_VEC[v][0]);
        end

        // R4: merged five-input function
        tf = 16'hA5C3; tg = 16'h3C96;
        configure(mk(tf, tg, 1, 0, 0, 0, 0));
        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 2; s++) begin
                set_in(4'(i), 4'(15 - i), s[0], 0);
                chk("R4 merged out_x", out_x, s[0] ? tg[i] : tf[i]);
                chk("R4 merged out_y", out_y, tg[15 - i]);
            end
        end

        // R5: out_x registered, out_y combinational; both tables follow bit 0
        configure(mk(16'hAAAA, 16'hAAAA, 0, 0, 1, 0, 0));
        set_in(4'h0, 4'h0, 0, 0);
        @(negedge clk); #2;
        chk("R5 reg settled", out_x, 1'b0);
        set_in(4'h1, 4'h1, 0, 0);
        chk("R5 reg holds", out_x, 1'b0);
        chk("R5 comb follows", out_y, 1'b1);
        @(negedge clk); #2;
        chk("R5 reg updated", out_x, 1'b1);

        // R6: 2-bit adder slice, XOR3 tables; address bit 2 forced high to show override
        configure(mk(16'h9696, 16'h9696, 0, 0, 0, 0, 1));
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 2; c++) begin
                    s3 = 5'(a + b + c);
                    set_in({1'b0, 1'b1, b[0], a[0]}, {1'b0, 1'b1, b[1], a[1]}, 0, c[0]);
                    chk("R6 sum0", out_x, s3[0]);
                    chk("R6 sum1", out_y, s3[1]);
                    chk("R6 cout", cout, s3[2]);
                end
        configure(mk(16'h9696, 16'h9696, 0, 0, 0, 0, 0));
        set_in(4'b0011, 4'b0011, 0, 1);
        chk("R6 cout off", cout, 1'b0);

        // R7: RAM mode
        configure(mk(16'h0000, 16'h0000, 0, 1, 0, 0, 0));
        set_in(4'h5, 4'h0, 0, 0);
        ram_din = 1; ram_we = 1;
        @(negedge clk);
        set_in(4'h9, 4'h0, 1, 0);
        @(negedge clk);
        ram_we = 0;
        set_in(4'h5, 4'h9, 0, 0);
        chk("R7 read F5", out_x, 1'b1);
        chk("R7 read G9 via g_in", out_y, 1'b1);
        set_in(4'h5, 4'h5, 1, 0);
        chk("R7 read G5", out_x, 1'b0);
        chk("R7 out_y G5", out_y, 1'b0);
        set_in(4'h9, 4'h0, 1, 0);
        chk("R7 read G9", out_x, 1'b1);
        set_in(4'h5, 4'h0, 0, 0);
        ram_din = 0; ram_we = 1;
        @(negedge clk);
        ram_we = 0; #2;
        chk("R7 overwrite F5", out_x, 1'b0);

        // R8: write enable ignored outside RAM mode
        configure(mk(16'h0000, 16'h0000, 0, 0, 0, 0, 0));
        set_in(4'h3, 4'h3, 0, 0);
        ram_din = 1; ram_we = 1;
        @(negedge clk);
        ram_we = 0; #2;
        chk("R8 F3 unchanged", out_x, 1'b0);
        set_in(4'h3, 4'h3, 1, 0);
        ram_we = 1;
        @(negedge clk);
        ram_we = 0; #2;
        chk("R8 G3 unchanged", out_y, 1'b0);

        // R9: extra shifts after completion are ignored
        shift_bits(mk(16'hFFFF, 16'hFFFF, 1, 1, 1, 1, 1), 36, 0);
        set_in(4'h3, 4'h3, 0, 1);
        chk("R9 out_x unchanged", out_x, 1'b0);
        chk("R9 out_y unchanged", out_y, 1'b0);
        chk("R9 cout unchanged", cout, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule